// File: doc/BRIEF.md
# Burst SRAM Command Controller

This block is the clocked control path of a synchronous burst SRAM with a small register-file array inside it. On every rising edge it decodes two active-low address strobes, a burst-advance input, three chip enables and the global/byte write controls into one of five commands: deselect, begin a read burst, begin a write burst, continue the burst, or suspend it. A begin loads the burst start from the external address. Continue and suspend step or hold a two-bit beat counter, which walks the low address bits in linear or interleaved order.

Writes take their data and byte mask in the same cycle as the command. Reads go through a synchronous array read. A mode input chooses between two read paths. In flow-through mode the data drives in the cycle after the read edge. In pipelined mode it passes one more register and drives a cycle later. A deselect is pipelined as deeply as a read, so the data outputs stay on for one more cycle and turn off only after the second edge (dual-cycle deselect). Tri-state drivers are modelled as a data bus plus a drive-enable. An asynchronous output-enable acts as a combinational mask on that enable.

Top module: `burst_sram_ctrl`

## Requirements
- R1: Chip enable is true only with ce1_n_i=0, ce2_i=1 and ce3_n_i=0. A cycle that asserts a strobe while chip enable is false is a deselect. It writes nothing and ends the burst, so a later advance accesses nothing.
- R2: adsp_n_i=0 with ce1_n_i=0 and chip enable true begins a read burst at addr_i, even when gw_n_i or bw_n_i is asserted.
- R3: ce1_n_i=1 masks adsp_n_i. With adsc_n_i=1 the cycle then acts as a continue (adv_n_i=0) or a suspend (adv_n_i=1) of the live burst.
- R4: adsc_n_i=0, with adsp_n_i high or masked and chip enable true, begins a burst at addr_i. The burst is a write if the write decode selects any byte, otherwise a read.
- R5: A continue (both strobes inactive, adv_n_i=0) advances beat n, which starts at 0 and wraps after 3, and accesses low bits (start+n) mod 4 when linear_i=1 or start XOR n when linear_i=0. The upper address bits stay as loaded.
- R6: A suspend (both strobes inactive, adv_n_i=1) repeats the access at the current burst address.
- R7: gw_n_i=0 writes all bytes. Otherwise bw_n_i=0 writes byte i (wdata_i bits [8i+7:8i]) for each be_n_i[i]=0. Otherwise the cycle reads. Data and mask are sampled with the command.
- R8: In the cycle after a write edge, dq_oe_o is 0 in both read modes.
- R9: Read data for an access at edge k drives after edge k when pipe_i=0, and after edge k+1 when pipe_i=1.
- R10: A cycle that makes no access keeps the outputs governed by the earlier read for one more cycle. If neither of the last two edges performed a read, dq_oe_o is 0.
- R11: oe_n_i=1 forces dq_oe_o to 0 at once, without waiting for a clock edge.
- R12: While and after reset, dq_oe_o is 0 and no burst is live, so an advance accesses nothing.
- R13: dq_o is all zeros whenever dq_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| adsp_n_i | input | 1 | Processor-side address strobe, active low |
| adsc_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce1_n_i | input | 1 | Chip enable, active low; also masks adsp_n_i |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_n_i | input | 1 | Chip enable, active low |
| gw_n_i | input | 1 | Write all bytes, active low |
| bw_n_i | input | 1 | Byte write qualifier, active low |
| be_n_i | input | BYTES | Per-byte write select, active low |
| wdata_i | input | BYTES*BYTE_W | Write data |
| pipe_i | input | 1 | 1 = pipelined reads, 0 = flow-through |
| linear_i | input | 1 | 1 = linear beat order, 0 = interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_o | output | BYTES*BYTE_W | Read data, zero when not driving |
| dq_oe_o | output | 1 | Output driver enable |

## Verification
The hardest situation to reach is the overlap of the two output stages. Examples are a flow-through deselect while an older read still owns the bus, a write that follows a read directly in pipelined mode, and an advance after a masked strobe or a failed enable that must touch nothing. Directed sequences set up each overlap on purpose after the array has been filled with known data. Seeded random traffic then mixes strobe, enable and write patterns. It biases chip enable mostly true and switches read mode and beat order every few hundred cycles, so that these overlaps recur around mode changes.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL    = 3'd0,
    CMD_BEGIN_RD = 3'd1,
    CMD_BEGIN_WR = 3'd2,
    CMD_CONT     = 3'd3,
    CMD_SUSP     = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Low two address bits for beat number `beat` of a burst starting at `start`.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       linear);
    logic [1:0] sum;
    sum = start + beat;
    return linear ? sum : (start ^ beat);
  endfunction

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             adsp_n_i,
  input  logic             adsc_n_i,
  input  logic             adv_n_i,
  input  logic             ce1_n_i,
  input  logic             ce2_i,
  input  logic             ce3_n_i,
  input  logic             gw_n_i,
  input  logic             bw_n_i,
  input  logic [BYTES-1:0] be_n_i,
  output cmd_e             cmd_o,
  output logic [BYTES-1:0] wmask_o
);

  logic chip_on;

  always_comb begin
    chip_on = !ce1_n_i && ce2_i && !ce3_n_i;

    if (!gw_n_i)      wmask_o = '1;
    else if (!bw_n_i) wmask_o = ~be_n_i;
    else              wmask_o = '0;

    // Priority: unmasked processor strobe, controller strobe, advance.
    if (!adsp_n_i && !ce1_n_i)
      cmd_o = chip_on ? CMD_BEGIN_RD : CMD_DESEL;
    else if (!adsc_n_i)
      cmd_o = chip_on ? ((|wmask_o) ? CMD_BEGIN_WR : CMD_BEGIN_RD) : CMD_DESEL;
    else if (!adv_n_i)
      cmd_o = CMD_CONT;
    else
      cmd_o = CMD_SUSP;
  end

endmodule

// File: rtl/sbc_addr_seq.sv
module sbc_addr_seq
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              linear_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              live_o
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] upper_q;
  logic [1:0]      start_q;
  logic [1:0]      beat_q;
  logic [1:0]      beat_use;
  logic            live_q;

  always_comb begin
    beat_use   = (cmd_i == CMD_CONT) ? beat_q + 2'd1 : beat_q;
    acc_addr_o = {upper_q, beat_offset(start_q, beat_use, linear_i)};
    if (cmd_i == CMD_BEGIN_RD || cmd_i == CMD_BEGIN_WR)
      acc_addr_o = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      live_q  <= 1'b0;
    end else begin
      case (cmd_i)
        CMD_BEGIN_RD, CMD_BEGIN_WR: begin
          upper_q <= addr_i[ADDR_W-1:2];
          start_q <= addr_i[1:0];
          beat_q  <= 2'd0;
          live_q  <= 1'b1;
        end
        CMD_DESEL: live_q <= 1'b0;
        CMD_CONT:  if (live_q) beat_q <= beat_use;
        default:   ;
      endcase
    end
  end

  assign live_o = live_q;

endmodule

// File: rtl/sbc_mem.sv
module sbc_mem #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic [BYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we_i[g]) lane_mem[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
      rd_q <= lane_mem[addr_i];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = rd_q;
  end

endmodule

// File: rtl/sbc_out_stage.sv
module sbc_out_stage
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              pipe_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  acc_e              kind1_q;
  acc_e              kind2_q;
  logic [DATA_W-1:0] data2_q;
  logic              drive;
  logic [DATA_W-1:0] src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind1_q <= ACC_NONE;
      kind2_q <= ACC_NONE;
    end else begin
      kind1_q <= acc_i;
      kind2_q <= kind1_q;
    end
  end

  always_ff @(posedge clk) data2_q <= rdata_i;

  always_comb begin
    if (pipe_i) begin
      drive = (kind2_q == ACC_READ) && (kind1_q != ACC_WRITE);
      src   = data2_q;
    end else begin
      drive = (kind1_q == ACC_READ) ||
              ((kind1_q == ACC_NONE) && (kind2_q == ACC_READ));
      src   = (kind1_q == ACC_READ) ? rdata_i : data2_q;
    end
    dq_oe_o = drive && !oe_n_i;
    dq_o    = dq_oe_o ? src : '0;
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sbc_pkg::*;
#(
  parameter  int ADDR_W = 6,
  parameter  int BYTES  = 4,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_n_i,
  input  logic              adsc_n_i,
  input  logic              adv_n_i,
  input  logic              ce1_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  logic              gw_n_i,
  input  logic              bw_n_i,
  input  logic [BYTES-1:0]  be_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pipe_i,
  input  logic              linear_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  cmd_e              cmd;
  logic [BYTES-1:0]  wmask;
  logic [ADDR_W-1:0] acc_addr;
  logic              live;
  acc_e              acc_kind;
  logic [BYTES-1:0]  mem_we;
  logic [DATA_W-1:0] rdata;

  sbc_decode #(.BYTES(BYTES)) u_decode (
    .adsp_n_i (adsp_n_i),
    .adsc_n_i (adsc_n_i),
    .adv_n_i  (adv_n_i),
    .ce1_n_i  (ce1_n_i),
    .ce2_i    (ce2_i),
    .ce3_n_i  (ce3_n_i),
    .gw_n_i   (gw_n_i),
    .bw_n_i   (bw_n_i),
    .be_n_i   (be_n_i),
    .cmd_o    (cmd),
    .wmask_o  (wmask)
  );

  sbc_addr_seq #(.ADDR_W(ADDR_W)) u_addr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .addr_i     (addr_i),
    .linear_i   (linear_i),
    .acc_addr_o (acc_addr),
    .live_o     (live)
  );

  always_comb begin
    case (cmd)
      CMD_BEGIN_RD:      acc_kind = ACC_READ;
      CMD_BEGIN_WR:      acc_kind = ACC_WRITE;
      CMD_CONT, CMD_SUSP:
        acc_kind = !live ? ACC_NONE : ((|wmask) ? ACC_WRITE : ACC_READ);
      default:           acc_kind = ACC_NONE;
    endcase
    mem_we = (acc_kind == ACC_WRITE) ? wmask : '0;
  end

  sbc_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .addr_i  (acc_addr),
    .wdata_i (wdata_i),
    .rdata_o (rdata)
  );

  sbc_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_i   (acc_kind),
    .rdata_i (rdata),
    .pipe_i  (pipe_i),
    .oe_n_i  (oe_n_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

endmodule

// File: rtl/sbc_ctrl_chk.sv
module sbc_ctrl_chk
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_i,
  input logic              oe_n_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic [BYTES-1:0]  mem_we,
  input acc_e              acc_kind
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  a_r11_oe_masks: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !dq_oe_o);

  a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_o |-> (dq_o == '0));

  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && |$past(mem_we)) |-> !dq_oe_o);

  a_r10_dcd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && $past(acc_kind) != ACC_READ &&
     $past(acc_kind, 2) != ACC_READ) |-> !dq_oe_o);

  a_r9_pipe_source: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && pipe_i && dq_oe_o) |-> ($past(acc_kind, 2) == ACC_READ));

  always @(posedge clk) begin
    if (!rst_n) a_r12_reset_quiet: assert (!dq_oe_o);
  end

endmodule

bind burst_sram_ctrl sbc_ctrl_chk #(.DATA_W(DATA_W), .BYTES(BYTES)) i_sbc_ctrl_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pipe_i   (pipe_i),
  .oe_n_i   (oe_n_i),
  .dq_o     (dq_o),
  .dq_oe_o  (dq_oe_o),
  .mem_we   (mem_we),
  .acc_kind (acc_kind)
);

// File: tb/test_burst_sram_ctrl.sv
module test_burst_sram_ctrl;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bw_n;
  logic [NB-1:0] be_n;
  logic [DW-1:0] wdata;
  logic          pipe, linear, oe_n;
  logic [DW-1:0] dq;
  logic          dq_oe;

  burst_sram_ctrl i_burst_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .adsp_n_i(adsp_n), .adsc_n_i(adsc_n),
    .adv_n_i(adv_n), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n), .gw_n_i(gw_n),
    .bw_n_i(bw_n), .be_n_i(be_n), .wdata_i(wdata), .pipe_i(pipe), .linear_i(linear),
    .oe_n_i(oe_n), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_tag = "";

  // Reference model state. Kind codes: 0 none, 1 read, 2 write.
  logic [DW-1:0] ref_mem [64];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  bit            m_live = 0;
  int            k1 = 0, k2 = 0;
  logic [DW-1:0] d1 = '0, d2 = '0;

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] n, logic lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + n) : (b[1:0] ^ n);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    bit            ee;
    logic [DW-1:0] src;
    string         t;
    if (pipe) begin
      ee  = (k2 == 1) && (k1 != 2);
      src = d2;
    end else begin
      ee  = (k1 == 1) || (k1 == 0 && k2 == 1);
      src = (k1 == 1) ? d1 : d2;
    end
    if (oe_n) ee = 0;
    if (cur_tag != "") t = cur_tag;
    else t = oe_n ? "R11" : (ee ? "R9" : "R13");
    chk(t, "drive", {31'b0, dq_oe}, {31'b0, ee});
    chk(t, "dq", dq, ee ? src : '0);
  endtask

  task automatic cyc();
    bit            en_ok;
    logic [3:0]    wm;
    int            kind;
    logic [AW-1:0] a, nb;
    logic [1:0]    nbeat;
    bit            nlive;
    logic [DW-1:0] nd1, wd;
    en_ok = !ce1_n && ce2 && !ce3_n;
    wm    = !gw_n ? 4'hF : (!bw_n ? ~be_n : 4'h0);
    kind  = 0; a = '0; nb = m_base; nbeat = m_beat; nlive = m_live;
    if (!adsp_n && !ce1_n) begin
      if (en_ok) begin kind = 1; a = addr; nb = addr; nbeat = 0; nlive = 1; end
      else nlive = 0;
    end else if (!adsc_n) begin
      if (en_ok) begin kind = (wm != 0) ? 2 : 1; a = addr; nb = addr; nbeat = 0; nlive = 1; end
      else nlive = 0;
    end else if (m_live) begin
      if (!adv_n) nbeat = m_beat + 2'd1;
      a    = beat_addr(m_base, nbeat, linear);
      kind = (wm != 0) ? 2 : 1;
    end
    nd1 = (kind == 1) ? ref_mem[a] : '0;
    wd  = wdata;
    @(posedge clk);
    if (kind == 2)
      for (int i = 0; i < NB; i++) if (wm[i]) ref_mem[a][8*i +: 8] = wd[8*i +: 8];
    k2 = k1; d2 = d1; k1 = kind; d1 = nd1;
    m_base = nb; m_beat = nbeat; m_live = nlive;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic set_idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bw_n = 1; be_n = '1; oe_n = 0;
  endtask

  task automatic desel();
    set_idle(); ce1_n = 1; adsc_n = 0; cyc(); set_idle();
  endtask

  task automatic begin_rd_c(logic [AW-1:0] at);
    set_idle(); adsc_n = 0; addr = at; cyc(); set_idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd4242);
    rst_n = 0; addr = '0; wdata = '0; pipe = 1; linear = 1;
    set_idle();
    repeat (3) @(negedge clk);
    chk("R12", "drive in reset", {31'b0, dq_oe}, 32'd0);
    rst_n = 1;
    // R12: an advance right after reset accesses nothing.
    cur_tag = "R12";
    adv_n = 0; cyc(); cyc(); set_idle();

    // R4/R7/R8: fill the array with write bursts (global write), outputs quiet.
    cur_tag = "R8";
    for (int blk = 0; blk < 16; blk++) begin
      set_idle(); adsc_n = 0; gw_n = 0; addr = AW'(blk * 4); wdata = $urandom; cyc();
      adsc_n = 1; adv_n = 0;
      for (int j = 0; j < 3; j++) begin wdata = $urandom; cyc(); end
    end
    desel();

    // R7: byte write of lanes 0 and 2 only, then read it back.
    cur_tag = "R7";
    set_idle(); adsc_n = 0; bw_n = 0; be_n = 4'b1010; addr = 6'd13; wdata = 32'hFFFF_FFFF; cyc();
    begin_rd_c(6'd13); cyc(); desel(); cyc(); cyc();

    // R2: processor strobe reads even with global write asserted.
    cur_tag = "R2";
    set_idle(); adsp_n = 0; gw_n = 0; addr = 6'd21; cyc(); set_idle(); cyc();
    // R5: linear continue 22,23,20,21 (wrap).
    cur_tag = "R5";
    adv_n = 0; repeat (4) cyc(); set_idle();
    cur_tag = "R6";
    repeat (2) cyc();
    cur_tag = "R10";
    desel(); repeat (3) cyc();
    cur_tag = "R13";
    cyc();

    // R3: ce1 high masks processor strobe, cycle continues the burst.
    cur_tag = "R3";
    begin_rd_c(6'd30);
    ce1_n = 1; adsp_n = 0; adv_n = 0; cyc();
    adv_n = 1; cyc();
    desel(); cyc(); cyc();

    // R1: strobes with enables false write nothing and end the burst.
    cur_tag = "R1";
    set_idle(); adsc_n = 0; ce2 = 0; gw_n = 0; addr = 6'd40; wdata = 32'h0; cyc();
    set_idle(); adsp_n = 0; ce3_n = 1; addr = 6'd40; cyc();
    set_idle(); adv_n = 0; gw_n = 0; wdata = 32'h0; cyc(); cyc();
    begin_rd_c(6'd40); cyc(); desel(); cyc(); cyc();

    // R4: controller strobe write then read of same word.
    cur_tag = "R4";
    set_idle(); adsc_n = 0; gw_n = 0; addr = 6'd44; wdata = 32'hA5C3_0F1E; cyc();
    begin_rd_c(6'd44); cyc(); desel(); cyc(); cyc();

    // R5: interleaved order from low bits 2: 6,7,4,5.
    cur_tag = "R5";
    linear = 0;
    begin_rd_c(6'd46); adv_n = 0; repeat (3) cyc(); desel(); cyc(); cyc();
    linear = 1;

    // R9/R10: flow-through read then deselect.
    pipe = 0;
    cur_tag = "R9";
    begin_rd_c(6'd50); adv_n = 0; repeat (2) cyc();
    cur_tag = "R10";
    desel(); cyc(); cyc();
    pipe = 1;

    // R11: output enable high while a read burst runs.
    cur_tag = "R11";
    begin_rd_c(6'd3); adv_n = 0; oe_n = 1; cyc(); cyc(); oe_n = 0; cyc();
    desel(); cyc(); cyc();

    // R8: write right after a read in pipelined mode.
    cur_tag = "R8";
    begin_rd_c(6'd8);
    set_idle(); adsc_n = 0; gw_n = 0; addr = 6'd9; wdata = 32'h1234_5678; cyc();
    desel(); cyc(); cyc();

    // Seeded random traffic.
    cur_tag = "";
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) begin pipe = $urandom % 2; linear = $urandom % 2; end
      adsp_n = ($urandom % 4) != 0;
      adsc_n = ($urandom % 3) != 0;
      adv_n  = $urandom % 2;
      ce1_n  = ($urandom % 6) == 0;
      ce2    = ($urandom % 8) != 0;
      ce3_n  = ($urandom % 8) == 0;
      gw_n   = ($urandom % 4) != 0;
      bw_n   = $urandom % 2;
      be_n   = NB'($urandom);
      addr   = AW'($urandom);
      wdata  = $urandom;
      oe_n   = ($urandom % 8) == 0;
      cyc();
    end

    summary();
    $finish;
  end

endmodule